// File: doc/BRIEF.md
# Logarithmic Volume Envelope Ramper

This block holds, for each voice of a wavetable synthesizer, a 12-bit logarithmic volume word (a 4-bit exponent above an 8-bit mantissa) and walks it between a lower and an upper bound by a programmable step. Software programs each voice through a register write/read port that takes a register index, a voice number and a 16-bit data word. A sequencer elsewhere in the chip then presents one update slot per cycle, naming the voice whose turn it is. On a slot the voice may take a step, and the block reports that voice's volume one cycle later.

A ramp can run once and stop at its bound, restart from the opposite bound, reverse direction at each bound, or run straight past a bound and only report it. Reaching a bound can raise an interrupt. Software finds the lowest-numbered voice with a pending interrupt through a source register and acknowledges it by rewriting that voice's control byte. Conversion of the log volume to a linear gain is left to the consumer of `vol_out`.

Top module: `vol_ramp_gen`

## Requirements
- R1: After reset every voice reads control 0x0001 (halted, all else clear), volume 0, rate 0 and both bounds 0. `vol_out` is 0, `irq_out` is low and the source register reads 0.
- R2: A write with `reg_wr` high stores data[7:0] as the rate byte at index 0x06, as the lower bound at 0x07, as the upper bound at 0x08 and as the control byte at 0x0D. At index 0x09 it stores data[15:4] as the volume. The same registers read back at the index plus 0x80, with volume in bits 15-4 and every unused bit 0. A write at any other index changes nothing.
- R3: When a step applies, the amount in rate bits 5-0 is added to the 12-bit volume if control bit 6 is 0 and subtracted if it is 1. `vol_out` shows the slot voice's volume in the cycle after the slot.
- R4: Rate bits 7-6 (0,1,2,3) make a step apply on every 1st, 8th, 64th or 512th slot that the running voice receives. Writing the rate byte restarts this count, so the next such slot steps.
- R5: A step reaches its bound when the result's upper 8 bits are at or above the upper bound going up, or at or below the lower bound going down, or when it carries out of or borrows past 12 bits. With control bit 3 clear, the volume is then clamped to {bound, 0000} and control bit 0 (halted) is set.
- R6: With bit 3 set and bit 4 clear, reaching the bound reloads the volume with {opposite bound, 0000} and the ramp keeps running.
- R7: With bits 3 and 4 both set, reaching the bound clamps to {bound, 0000} and inverts control bit 6.
- R8: With control bit 2 set, reaching the bound stores the 12-bit wrapped result. Control bits 0 and 6 stay unchanged.
- R9: Reaching a bound with control bit 5 set sets control bit 7 (pending). `irq_out` is high exactly while some voice is pending. Any control write to a voice clears that voice's pending bit.
- R10: Index 0x8F reads bit 6 = any voice pending and bits 4-0 = the lowest-numbered pending voice. All other bits read 0, and the whole word reads 0 when nothing is pending.
- R11: A slot for a halted voice leaves its volume and its rate count unchanged. A slot for a running voice with control bit 1 set takes no step and sets bit 0 instead.
- R12: If a register write targets the slot's voice in the same cycle, the write takes effect and the slot is dropped: no step and no advance of the rate count. `vol_out` then shows the volume as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for write and read |
| voice_sel | input | VSEL_W | Voice addressed by the register port |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_idx`/`voice_sel` (combinational) |
| slot_stb | input | 1 | Update slot for `slot_voice` this cycle |
| slot_voice | input | VSEL_W | Voice owning the update slot |
| vol_out | output | 12 | Volume of the last slot's voice, one cycle after the slot |
| irq_out | output | 1 | High while any voice has a pending ramp interrupt |

## Verification
A register write and an update slot can land on the same voice in the same cycle. The write must then win and the slot must be lost entirely. The bench forces this by driving a volume write and a slot for one voice together, with the rate selector at 8 just after a rate write. It expects `vol_out` to equal the written value. The following slot must step, and the one after that must not, which shows that the dropped slot did not advance the rate count. A control write that acknowledges an interrupt in the same cycle as a slot that hits the bound is covered by the rule that a write clears pending, and a clocked property watches it.

// File: rtl/vr_pkg.sv
package vr_pkg;

  // control byte of a voice; the bit order is what software sees
  typedef struct packed {
    logic pend;      // 7
    logic dir;       // 6: 0 = rising
    logic ien;       // 5
    logic bidir;     // 4
    logic loop;      // 3
    logic roll;      // 2
    logic stop_req;  // 1
    logic stopped;   // 0
  } vr_ctrl_t;

  localparam logic [7:0] RD_FLAG   = 8'h80;
  localparam logic [7:0] IDX_RATE  = 8'h06;
  localparam logic [7:0] IDX_LO    = 8'h07;
  localparam logic [7:0] IDX_HI    = 8'h08;
  localparam logic [7:0] IDX_VOL   = 8'h09;
  localparam logic [7:0] IDX_CTRL  = 8'h0D;
  localparam logic [7:0] IDX_SRC   = 8'h0F;

  localparam int VOL_W   = 12;
  localparam int BND_W   = 8;
  localparam int AMT_W   = 6;
  localparam int SEL_W   = 2;
  localparam int DIV_SH  = 3;
  localparam int CNT_W   = DIV_SH * ((1 << SEL_W) - 1);

endpackage

// File: rtl/vr_rst_sync.sv
module vr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/vr_prescale.sv
module vr_prescale #(
  parameter int CNT_W = 9,
  parameter int SEL_W = 2,
  parameter int DIV_SH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             cnt_en;

  always_comb begin
    mask   = ~({CNT_W{1'b1}} << (DIV_SH * int'(sel)));
    tick   = ((cnt_q & mask) == '0);
    cnt_en = clr | adv;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vr_stepper.sv
module vr_stepper
  import vr_pkg::*;
#(
  parameter int VW = 12,
  parameter int BW = 8,
  parameter int AW = 6
) (
  input  logic [VW-1:0] vol,
  input  logic [AW-1:0] amt,
  input  logic [BW-1:0] lo,
  input  logic [BW-1:0] hi,
  input  vr_ctrl_t      ctrl_in,
  output logic [VW-1:0] vol_new,
  output vr_ctrl_t      ctrl_new,
  output logic          hit
);
  localparam int FW = VW - BW;

  logic [VW:0]   amt_x, sum, dif;
  logic [VW-1:0] raw;
  logic [BW-1:0] tgt, opp;
  logic          up;

  always_comb begin
    up    = ~ctrl_in.dir;
    amt_x = (VW + 1)'(amt);
    sum   = {1'b0, vol} + amt_x;
    dif   = {1'b0, vol} - amt_x;
    if (up) begin
      raw = sum[VW-1:0];
      hit = sum[VW] | (sum[VW-1:FW] >= hi);
      tgt = hi;
      opp = lo;
    end else begin
      raw = dif[VW-1:0];
      hit = dif[VW] | (dif[VW-1:FW] <= lo);
      tgt = lo;
      opp = hi;
    end

    ctrl_new = ctrl_in;
    vol_new  = raw;
    if (hit) begin
      if (ctrl_in.ien) ctrl_new.pend = 1'b1;
      if (ctrl_in.roll) begin
        vol_new = raw;
      end else if (!ctrl_in.loop) begin
        vol_new          = {tgt, {FW{1'b0}}};
        ctrl_new.stopped = 1'b1;
      end else if (ctrl_in.bidir) begin
        vol_new      = {tgt, {FW{1'b0}}};
        ctrl_new.dir = ~ctrl_in.dir;
      end else begin
        vol_new = {opp, {FW{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/vr_irq_pick.sv
module vr_irq_pick #(
  parameter int N = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/vol_ramp_gen.sv
module vol_ramp_gen
  import vr_pkg::*;
#(
  parameter  int NUM_VOICES = 4,
  localparam int VSEL_W = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_idx,
  input  logic [VSEL_W-1:0] voice_sel,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              slot_stb,
  input  logic [VSEL_W-1:0] slot_voice,
  output logic [11:0]       vol_out,
  output logic              irq_out
);
  localparam int NV = NUM_VOICES;
  localparam int FW = VOL_W - BND_W;

  logic rst_q_n;

  logic [NV-1:0][7:0]       rate_q, rate_d, lo_q, lo_d, hi_q, hi_d;
  logic [NV-1:0][VOL_W-1:0] vol_q, vol_d;
  vr_ctrl_t [NV-1:0]        ctrl_q, ctrl_d;
  logic [VOL_W-1:0]         vol_out_q, vol_out_d;

  logic [NV-1:0] wr_hit_v, slot_v, adv_v, clr_v, tick_v, en_v;
  logic [NV-1:0] pend_v, stopped_v, stopreq_v;
  logic          wr_known;

  logic [VOL_W-1:0] st_vol;
  vr_ctrl_t         st_ctrl;
  logic             st_hit;

  logic              pick_any;
  logic [VSEL_W-1:0] pick_idx;

  vr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  // register port decode
  always_comb begin
    wr_known = reg_wr && ((reg_idx == IDX_RATE) || (reg_idx == IDX_LO) ||
                          (reg_idx == IDX_HI) || (reg_idx == IDX_VOL) ||
                          (reg_idx == IDX_CTRL));
    for (int v = 0; v < NV; v++) begin
      wr_hit_v[v]  = wr_known && (voice_sel == VSEL_W'(v));
      clr_v[v]     = wr_hit_v[v] && (reg_idx == IDX_RATE);
      slot_v[v]    = slot_stb && (slot_voice == VSEL_W'(v)) && !wr_hit_v[v];
      adv_v[v]     = slot_v[v] && !ctrl_q[v].stopped && !ctrl_q[v].stop_req;
      en_v[v]      = wr_hit_v[v] || slot_v[v];
      pend_v[v]    = ctrl_q[v].pend;
      stopped_v[v] = ctrl_q[v].stopped;
      stopreq_v[v] = ctrl_q[v].stop_req;
    end
  end

  // one rate counter per voice
  for (genvar g = 0; g < NV; g++) begin : g_div
    vr_prescale #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DIV_SH(DIV_SH)) u_div (
      .clk  (clk),
      .rst_n(rst_q_n),
      .clr  (clr_v[g]),
      .adv  (adv_v[g]),
      .sel  (rate_q[g][7:8-SEL_W]),
      .tick (tick_v[g])
    );
  end

  // a single step datapath, shared by the voices through the slot
  vr_stepper #(.VW(VOL_W), .BW(BND_W), .AW(AMT_W)) u_step (
    .vol     (vol_q[slot_voice]),
    .amt     (rate_q[slot_voice][AMT_W-1:0]),
    .lo      (lo_q[slot_voice]),
    .hi      (hi_q[slot_voice]),
    .ctrl_in (ctrl_q[slot_voice]),
    .vol_new (st_vol),
    .ctrl_new(st_ctrl),
    .hit     (st_hit)
  );

  vr_irq_pick #(.N(NV), .IDX_W(VSEL_W)) u_pick (
    .pend(pend_v), .any(pick_any), .idx(pick_idx)
  );

  // next state
  always_comb begin
    rate_d = rate_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    vol_d  = vol_q;
    ctrl_d = ctrl_q;
    for (int v = 0; v < NV; v++) begin
      if (wr_hit_v[v]) begin
        case (reg_idx)
          IDX_RATE: rate_d[v] = wr_data[7:0];
          IDX_LO:   lo_d[v]   = wr_data[7:0];
          IDX_HI:   hi_d[v]   = wr_data[7:0];
          IDX_VOL:  vol_d[v]  = wr_data[15:FW];
          IDX_CTRL: begin
            ctrl_d[v]      = vr_ctrl_t'(wr_data[7:0]);
            ctrl_d[v].pend = 1'b0;
          end
          default: ;
        endcase
      end else if (slot_v[v] && !ctrl_q[v].stopped) begin
        if (ctrl_q[v].stop_req) begin
          ctrl_d[v].stopped = 1'b1;
        end else if (tick_v[v]) begin
          vol_d[v]  = st_vol;
          ctrl_d[v] = st_ctrl;
        end
      end
    end
    vol_out_d = vol_d[slot_voice];
  end

  // state registers with written-out enables
  for (genvar g = 0; g < NV; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        rate_q[g] <= '0;
        lo_q[g]   <= '0;
        hi_q[g]   <= '0;
        vol_q[g]  <= '0;
        ctrl_q[g] <= vr_ctrl_t'(8'h01);
      end else if (en_v[g]) begin
        rate_q[g] <= rate_d[g];
        lo_q[g]   <= lo_d[g];
        hi_q[g]   <= hi_d[g];
        vol_q[g]  <= vol_d[g];
        ctrl_q[g] <= ctrl_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      vol_out_q <= '0;
    else if (slot_stb) vol_out_q <= vol_out_d;
  end

  // read side
  always_comb begin
    case (reg_idx)
      IDX_RATE | RD_FLAG: rd_data = {8'h00, rate_q[voice_sel]};
      IDX_LO   | RD_FLAG: rd_data = {8'h00, lo_q[voice_sel]};
      IDX_HI   | RD_FLAG: rd_data = {8'h00, hi_q[voice_sel]};
      IDX_VOL  | RD_FLAG: rd_data = {vol_q[voice_sel], {FW{1'b0}}};
      IDX_CTRL | RD_FLAG: rd_data = {8'h00, ctrl_q[voice_sel]};
      IDX_SRC  | RD_FLAG: rd_data = {8'h00, 1'b0, pick_any, 1'b0, 5'(pick_idx)};
      default:            rd_data = 16'h0000;
    endcase
  end

  assign vol_out = vol_out_q;
  assign irq_out = pick_any;

endmodule

// File: rtl/vol_ramp_chk.sv
module vol_ramp_chk #(
  parameter int NV = 4,
  parameter int VSEL_W = 2
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic                  reg_wr,
  input logic [7:0]            reg_idx,
  input logic [VSEL_W-1:0]     voice_sel,
  input logic [15:0]           wr_data,
  input logic [15:0]           rd_data,
  input logic                  slot_stb,
  input logic [VSEL_W-1:0]     slot_voice,
  input logic [11:0]           vol_out,
  input logic                  irq_out,
  input logic [NV-1:0][11:0]   vol_q,
  input logic [NV-1:0]         pend_v,
  input logic [NV-1:0]         stopped_v,
  input logic [NV-1:0]         stopreq_v
);
  logic same_voice_wr;
  assign same_voice_wr = reg_wr && (voice_sel == slot_voice);

  assert_out_tracks_state_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    slot_stb |=> (vol_out == vol_q[$past(slot_voice)]));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    (slot_stb && same_voice_wr && reg_idx == 8'h09) |=> (vol_out == $past(wr_data[15:4])));

  assert_halted_frozen_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (slot_stb && stopped_v[slot_voice] && !same_voice_wr)
      |=> (vol_q[$past(slot_voice)] == $past(vol_q[slot_voice])));

  assert_stop_lands_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (slot_stb && stopreq_v[slot_voice] && !stopped_v[slot_voice] && !same_voice_wr)
      |=> stopped_v[$past(slot_voice)]);

  assert_irq_is_any_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_out == (pend_v != '0));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr && reg_idx == 8'h0D) |=> !pend_v[$past(voice_sel)]);

  assert_src_flag_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_idx == 8'h8F) |-> (rd_data[6] == irq_out && rd_data[7] == 1'b0));

endmodule

bind vol_ramp_gen vol_ramp_chk #(.NV(NUM_VOICES), .VSEL_W(VSEL_W)) u_chk (
  .clk(clk), .rst_ok(rst_q_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .voice_sel(voice_sel), .wr_data(wr_data), .rd_data(rd_data),
  .slot_stb(slot_stb), .slot_voice(slot_voice), .vol_out(vol_out),
  .irq_out(irq_out), .vol_q(vol_q), .pend_v(pend_v),
  .stopped_v(stopped_v), .stopreq_v(stopreq_v)
);

// File: tb/sim_vol_ramp_gen.sv
`timescale 1ns/1ps
module sim_vol_ramp_gen;
  localparam int NV = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_idx;
  logic [1:0]  voice_sel;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        slot_stb;
  logic [1:0]  slot_voice;
  logic [11:0] vol_out;
  logic        irq_out;

  int n_chk;
  int n_fail;
  bit done;

  // reference state, built from the requirements
  int         m_vol [NV];
  int         m_cnt [NV];
  logic [7:0] m_ctrl[NV];
  logic [7:0] m_rate[NV];
  logic [7:0] m_lo  [NV];
  logic [7:0] m_hi  [NV];

  vol_ramp_gen #(.NUM_VOICES(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .voice_sel(voice_sel), .wr_data(wr_data), .rd_data(rd_data),
    .slot_stb(slot_stb), .slot_voice(slot_voice), .vol_out(vol_out),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit m_any();
    for (int v = 0; v < NV; v++) if (m_ctrl[v][7]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_write(input logic [7:0] i, input int v, input logic [15:0] d);
    case (i)
      8'h06: begin m_rate[v] = d[7:0]; m_cnt[v] = 0; end
      8'h07: m_lo[v] = d[7:0];
      8'h08: m_hi[v] = d[7:0];
      8'h09: m_vol[v] = int'(d[15:4]);
      8'h0D: m_ctrl[v] = d[7:0] & 8'h7F;
      default: ;
    endcase
  endtask

  task automatic m_slot(input int v);
    int amt, raw, tgt, opp, mask;
    bit up, hit, tk;
    if (m_ctrl[v][0]) return;
    if (m_ctrl[v][1]) begin m_ctrl[v][0] = 1'b1; return; end
    mask = (1 << (3 * int'(m_rate[v][7:6]))) - 1;
    tk = ((m_cnt[v] & mask) == 0);
    m_cnt[v] = (m_cnt[v] + 1) % 512;
    if (!tk) return;
    amt = int'(m_rate[v][5:0]);
    up  = !m_ctrl[v][6];
    if (up) begin
      raw = m_vol[v] + amt;
      hit = (raw > 4095) || (((raw % 4096) / 16) >= int'(m_hi[v]));
      tgt = m_hi[v]; opp = m_lo[v];
    end else begin
      raw = m_vol[v] - amt;
      hit = (raw < 0) || ((((raw + 4096) % 4096) / 16) <= int'(m_lo[v]));
      tgt = m_lo[v]; opp = m_hi[v];
    end
    raw = (raw + 4096) % 4096;
    if (!hit) m_vol[v] = raw;
    else begin
      if (m_ctrl[v][5]) m_ctrl[v][7] = 1'b1;
      if (m_ctrl[v][2]) m_vol[v] = raw;
      else if (!m_ctrl[v][3]) begin m_vol[v] = tgt * 16; m_ctrl[v][0] = 1'b1; end
      else if (m_ctrl[v][4]) begin m_vol[v] = tgt * 16; m_ctrl[v][6] = ~m_ctrl[v][6]; end
      else m_vol[v] = opp * 16;
    end
  endtask

  task automatic wr(input logic [7:0] i, input int v, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; voice_sel = v[1:0]; wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0;
    m_write(i, v, d);
  endtask

  task automatic rd(input logic [7:0] i, input int v, output logic [15:0] d);
    @(negedge clk);
    reg_idx = i; voice_sel = v[1:0];
    #1 d = rd_data;
  endtask

  task automatic slot(input int v, input string req);
    @(negedge clk);
    slot_stb = 1'b1; slot_voice = v[1:0];
    @(negedge clk);
    slot_stb = 1'b0;
    m_slot(v);
    chk(vol_out == m_vol[v][11:0], req, int'(vol_out), m_vol[v]);
    chk(irq_out == m_any(), "R9 irq_out", int'(irq_out), int'(m_any()));
  endtask

  task automatic collide(input int v, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 8'h09; voice_sel = v[1:0]; wr_data = d;
    slot_stb = 1'b1; slot_voice = v[1:0];
    @(negedge clk);
    reg_wr = 1'b0; slot_stb = 1'b0;
    m_write(8'h09, v, d);
    chk(vol_out == d[15:4], "R12 collision vol_out", int'(vol_out), int'(d[15:4]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  c;
    int v, amt, nsl;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = 8'h00; voice_sel = '0;
    wr_data = '0; slot_stb = 1'b0; slot_voice = '0;
    for (int k = 0; k < NV; k++) begin
      m_vol[k] = 0; m_cnt[k] = 0; m_ctrl[k] = 8'h01;
      m_rate[k] = 0; m_lo[k] = 0; m_hi[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NV; k++) begin
      rd(8'h8D, k, d); chk(d == 16'h0001, "R1 ctrl after reset", d, 16'h0001);
      rd(8'h89, k, d); chk(d == 16'h0000, "R1 volume after reset", d, 0);
      rd(8'h86, k, d); chk(d == 16'h0000, "R1 rate after reset", d, 0);
      rd(8'h87, k, d); chk(d == 16'h0000, "R1 lower bound after reset", d, 0);
      rd(8'h88, k, d); chk(d == 16'h0000, "R1 upper bound after reset", d, 0);
    end
    chk(vol_out == 12'h000, "R1 vol_out after reset", vol_out, 0);
    chk(irq_out == 1'b0, "R1 irq_out after reset", irq_out, 0);
    rd(8'h8F, 0, d); chk(d == 16'h0000, "R1 source after reset", d, 0);

    // R2 register map
    wr(8'h06, 2, 16'h1234); rd(8'h86, 2, d); chk(d == 16'h0034, "R2 rate readback", d, 16'h0034);
    wr(8'h07, 2, 16'hFFA5); rd(8'h87, 2, d); chk(d == 16'h00A5, "R2 lower readback", d, 16'h00A5);
    wr(8'h08, 2, 16'h005A); rd(8'h88, 2, d); chk(d == 16'h005A, "R2 upper readback", d, 16'h005A);
    wr(8'h09, 2, 16'hABCD); rd(8'h89, 2, d); chk(d == 16'hABC0, "R2 volume readback", d, 16'hABC0);
    wr(8'h0A, 2, 16'hFFFF); rd(8'h89, 2, d); chk(d == 16'hABC0, "R2 unknown index ignored", d, 16'hABC0);
    wr(8'h89, 2, 16'h1110); rd(8'h89, 2, d); chk(d == 16'hABC0, "R2 read index not writable", d, 16'hABC0);
    wr(8'h0D, 2, 16'hFF81); rd(8'h8D, 2, d); chk(d == 16'h0001, "R2 ctrl readback", d, 16'h0001);
    rd(8'h86, 0, d); chk(d == 16'h0000, "R2 other voice untouched", d, 0);

    // R3..R9 sweep over rate selector, mode and direction
    for (int sel = 0; sel < 4; sel++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int dn = 0; dn < 2; dn++) begin
          v   = (sel * 8 + mode * 2 + dn) % NV;
          amt = 40 + sel * 3 + mode;
          nsl = (sel == 3) ? 1100 : 300;
          wr(8'h06, v, {8'h00, sel[1:0], amt[5:0]});
          wr(8'h07, v, 16'h0020);
          wr(8'h08, v, 16'h00C0);
          wr(8'h09, v, (dn != 0) ? 16'hC000 : 16'h2000);
          c = {1'b0, dn[0], 1'b1, (mode == 2), (mode == 1 || mode == 2), (mode == 3), 2'b00};
          wr(8'h0D, v, {8'h00, c});
          for (int n = 0; n < nsl; n++) slot(v, "R3-step R4-rate R5/R6/R7/R8-bound");
          rd(8'h8D, v, d);
          chk(d[7:0] == m_ctrl[v], "R5 R7 R8 ctrl after sweep", d, m_ctrl[v]);
        end
      end
    end

    // R11 stop request and halted voice
    wr(8'h06, 1, 16'h0004); wr(8'h07, 1, 16'h0010); wr(8'h08, 1, 16'h00F0);
    wr(8'h09, 1, 16'h4000); wr(8'h0D, 1, 16'h0000);
    slot(1, "R3 rising step");
    chk(vol_out == 12'h404, "R3 literal step", vol_out, 12'h404);
    wr(8'h0D, 1, 16'h0002);
    slot(1, "R11 stop request slot");
    rd(8'h8D, 1, d); chk(d == 16'h0003, "R11 halted after stop request", d, 16'h0003);
    slot(1, "R11 halted slot");
    chk(vol_out == 12'h404, "R11 halted volume held", vol_out, 12'h404);

    // R9 / R10 interrupt source
    for (int k = 0; k < NV; k++) wr(8'h0D, k, 16'h0001);
    chk(irq_out == 1'b0, "R9 all acknowledged", irq_out, 0);
    for (int k = 3; k >= 1; k -= 2) begin
      wr(8'h06, k, 16'h003F); wr(8'h07, k, 16'h0010); wr(8'h08, k, 16'h0011);
      wr(8'h09, k, 16'h1000); wr(8'h0D, k, 16'h0020);
      slot(k, "R5 one-shot clamp");
      chk(vol_out == 12'h110, "R5 clamp literal", vol_out, 12'h110);
    end
    rd(8'h8F, 0, d); chk(d == 16'h0041, "R10 lowest pending voice", d, 16'h0041);
    wr(8'h0D, 1, 16'h0001);
    rd(8'h8F, 0, d); chk(d == 16'h0043, "R10 next pending voice", d, 16'h0043);
    wr(8'h0D, 3, 16'h0001);
    rd(8'h8F, 0, d); chk(d == 16'h0000, "R10 none pending", d, 0);
    chk(irq_out == 1'b0, "R9 cleared by control write", irq_out, 0);

    // R12 write and slot in the same cycle
    wr(8'h06, 0, 16'h004A); wr(8'h07, 0, 16'h0000); wr(8'h08, 0, 16'h00FF);
    wr(8'h09, 0, 16'h3000); wr(8'h0D, 0, 16'h0000);
    collide(0, 16'h5550);
    slot(0, "R12 slot after collision steps");
    chk(vol_out == 12'h55F, "R12 count not advanced", vol_out, 12'h55F);
    slot(0, "R4 divided slot holds");
    chk(vol_out == 12'h55F, "R4 no step on second slot", vol_out, 12'h55F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule